// File: doc/BRIEF.md
# Serial-In Shift Register with Held Parallel Outputs

This block takes a bit stream on one pin and presents it as a parallel word. It has two register banks. The first is a shift chain of `WIDTH` stages. Each rising edge of its shift clock moves the chain forward by one stage. The second is a storage bank. It copies the whole chain at once on a rising edge of its own transfer clock. Because the two clocks are independent, the parallel word can stay steady while the next word is shifted in behind it.

The parallel pins are driven from the storage bank. An active-low enable selects between two output modes. In `OUT_DRIVE` the pins carry the stored word. In `OUT_FLOAT` every pin is released to high impedance. The enable changes only the mode: it leaves both register banks as they were. An active-low clear empties the shift chain at once, with or without a clock edge, and leaves the storage bank alone. The last shift stage is also brought out as a serial cascade pin. Chaining blocks through that pin, with the clocks shared, gives a longer register.

The register banks have no reset state of their own. After power-up the expected sequence is this: hold the clear low, pulse the transfer clock once so that the storage bank takes the empty chain, then release the clear and begin shifting.

Top module: `ser_par_latch`

## Requirements
- R1: On each rising edge of `sclk` while `clr_n` is high, `ser_in` enters stage 0 (stage A) and stage i moves to stage i+1.
- R2: `ser_out` always equals the last shift stage (stage `WIDTH-1`, stage H) and follows it as it shifts.
- R3: A rising edge of `rclk` copies all shift stages into the storage bank at once. Stage i goes to `par_q[i]`, so bit 0 is stage A.
- R4: `par_q` reflects the storage bank only. Shift edges without an `rclk` edge leave `par_q` unchanged.
- R5: Driving `clr_n` low empties the shift chain and forces `ser_out` low at once, without any clock edge.
- R6: The clear leaves the storage bank unchanged.
- R7: With `oe_n` high (mode `OUT_FLOAT`) all `par_q` pins are high impedance. With `oe_n` low (mode `OUT_DRIVE`) they are driven with the storage bank.
- R8: `oe_n` has no effect on the contents of either bank. Edges taken while the outputs float are visible once the outputs are enabled again.
- R9: While `clr_n` is low, `sclk` edges do not shift, and the chain stays empty.
- R10: When `sclk` and `rclk` rise on the same edge, the storage bank takes the chain contents from before that shift.
- R11: Two blocks with the first block's `ser_out` wired to the second block's `ser_in`, sharing the clocks, the clear and the enable, behave as one shift register of `2*WIDTH` stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Shift clock; the chain advances on its rising edge |
| rclk | input | 1 | Transfer clock; the storage bank loads on its rising edge |
| clr_n | input | 1 | Active-low asynchronous clear of the shift chain only |
| oe_n | input | 1 | Active-low output enable for `par_q` |
| ser_in | input | 1 | Serial data into stage A |
| par_q | output | WIDTH | Tri-state parallel word from the storage bank |
| ser_out | output | 1 | Cascade output, the last shift stage |

## Verification
The hardest case to reach from the ports is a clock edge that arrives while a state-changing control is held. This covers a shift edge under a held clear, a transfer edge on the same edge as a shift, and edges taken while the outputs float. None of these shows on the pins until a later transfer with the outputs enabled.

The bench builds both clocks by gating one 250 MHz time base. It can therefore pulse the shift clock, the transfer clock or both in exactly the cycles it chooses. Some stimulus ends with the outputs floating or the chain cleared. After such stimulus the bench makes a transfer and enables the outputs, so the earlier effect becomes visible on the pins.

For the cascade case, two instances are chained and loaded from a pseudo-random stream longer than 16 bits.

// File: rtl/sr_pkg.sv
package sr_pkg;
    typedef enum logic {
        OUT_DRIVE = 1'b0,
        OUT_FLOAT = 1'b1
    } drv_mode_e;
endpackage

// File: rtl/sr_shift_chain.sv
module sr_shift_chain #(
    parameter int WIDTH = 8
) (
    input  logic             sclk,
    input  logic             clr_n,
    input  logic             din,
    output logic [WIDTH-1:0] stages
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] advance;

    generate
        if (WIDTH == 1) begin : g_single
            assign advance = din;
        end else begin : g_multi
            assign advance = {stages[MSB-1:0], din};
        end
    endgenerate

    always_ff @(posedge sclk or negedge clr_n) begin
        if (!clr_n) begin
            stages <= '0;
        end else begin
            stages <= advance;
        end
    end
endmodule

// File: rtl/sr_store_bank.sv
module sr_store_bank #(
    parameter int WIDTH = 8
) (
    input  logic             rclk,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge rclk) begin
        q <= d;
    end
endmodule

// File: rtl/sr_out_drive.sv
module sr_out_drive
    import sr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             oe_n,
    input  logic [WIDTH-1:0] word,
    output logic [WIDTH-1:0] pins
);
    drv_mode_e mode;
    logic      pin_en;

    always_comb begin
        mode = oe_n ? OUT_FLOAT : OUT_DRIVE;
    end

    always_comb begin
        unique case (mode)
            OUT_DRIVE: pin_en = 1'b1;
            OUT_FLOAT: pin_en = 1'b0;
            default:   pin_en = 1'b0;
        endcase
    end

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_pin
            assign pins[b] = pin_en ? word[b] : 1'bz;
        end
    endgenerate
endmodule

// File: rtl/ser_par_latch.sv
module ser_par_latch #(
    parameter int WIDTH = 8
) (
    input  logic             sclk,
    input  logic             rclk,
    input  logic             clr_n,
    input  logic             oe_n,
    input  logic             ser_in,
    output logic [WIDTH-1:0] par_q,
    output logic             ser_out
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] sh_q;
    logic [WIDTH-1:0] st_q;

    sr_shift_chain #(.WIDTH(WIDTH)) u_chain (
        .sclk   (sclk),
        .clr_n  (clr_n),
        .din    (ser_in),
        .stages (sh_q)
    );

    sr_store_bank #(.WIDTH(WIDTH)) u_store (
        .rclk (rclk),
        .d    (sh_q),
        .q    (st_q)
    );

    sr_out_drive #(.WIDTH(WIDTH)) u_drive (
        .oe_n (oe_n),
        .word (st_q),
        .pins (par_q)
    );

    assign ser_out = sh_q[MSB];
endmodule

// File: rtl/ser_par_latch_chk.sv
module ser_par_latch_chk #(
    parameter int WIDTH = 8
) (
    input logic             sclk,
    input logic             rclk,
    input logic             clr_n,
    input logic             ser_in,
    input logic             ser_out,
    input logic [WIDTH-1:0] sh_q,
    input logic [WIDTH-1:0] st_q
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] exp_sh  = '0;
    logic             sh_vld  = 1'b0;
    logic [WIDTH-1:0] exp_st  = '0;
    logic             st_vld  = 1'b0;

    always @(posedge sclk or negedge clr_n) begin
        if (!clr_n) begin
            sh_vld <= 1'b0;
            exp_sh <= '0;
        end else begin
            sh_vld <= 1'b1;
            exp_sh <= (sh_q << 1) | WIDTH'(ser_in);
        end
    end

    always @(posedge rclk) begin
        st_vld <= 1'b1;
        exp_st <= sh_q;
    end

    // R1: the chain after a shift edge holds the prior stages moved up one with the input in stage A
    a_r1_shift_moves: assert property (@(negedge sclk) disable iff (!clr_n)
        sh_vld |-> sh_q == exp_sh);

    // R2: cascade pin tracks the top stage after each shift
    a_r2_cascade_top: assert property (@(negedge sclk) disable iff (!clr_n)
        sh_vld |-> ser_out == exp_sh[MSB]);

    // R3 and R10: storage holds the chain as sampled at the transfer edge
    a_r3_store_copy: assert property (@(negedge rclk)
        st_vld |-> st_q == exp_st);

    // R5: while the clear is held the chain and cascade pin are zero
    a_r5_clear_empty: assert property (@(posedge rclk)
        !clr_n |-> (sh_q == '0 && ser_out == 1'b0));

    // R9: shift edges under a held clear find the chain empty
    a_r9_clear_wins: assert property (@(posedge sclk)
        !clr_n |-> sh_q == '0);
endmodule

bind ser_par_latch ser_par_latch_chk #(.WIDTH(WIDTH)) u_chk (
    .sclk    (sclk),
    .rclk    (rclk),
    .clr_n   (clr_n),
    .ser_in  (ser_in),
    .ser_out (ser_out),
    .sh_q    (sh_q),
    .st_q    (st_q)
);

// File: tb/test_ser_par_latch.sv
module test_ser_par_latch;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic sh_en = 1'b0;
    logic st_en = 1'b0;
    logic din   = 1'b0;
    logic clr_n = 1'b0;
    logic oe_n  = 1'b0;

    wire sclk = clk & sh_en;
    wire rclk = clk & st_en;

    wire [7:0] qa_bus;
    wire [7:0] qb_bus;
    wire       so_a;
    wire       so_b;

    for (genvar b = 0; b < 8; b++) begin : g_pu
        pullup (qa_bus[b]);
        pullup (qb_bus[b]);
    end

    ser_par_latch #(.WIDTH(8)) i_ser_par_latch (
        .sclk (sclk), .rclk (rclk), .clr_n (clr_n), .oe_n (oe_n),
        .ser_in (din), .par_q (qa_bus), .ser_out (so_a)
    );

    ser_par_latch #(.WIDTH(8)) i_tail (
        .sclk (sclk), .rclk (rclk), .clr_n (clr_n), .oe_n (oe_n),
        .ser_in (so_a), .par_q (qb_bus), .ser_out (so_b)
    );

    // behavioural reference: one 16-entry queue, index 0 is stage A of the first block
    bit       chain[$];
    bit [7:0] st_a = '0;
    bit [7:0] st_b = '0;
    int       n_cmp = 0;
    int       n_bad = 0;
    bit       done  = 1'b0;
    string    cur_req = "R5";

    initial begin
        for (int k = 0; k < 16; k++) chain.push_back(1'b0);
    end

    always @(posedge clk) begin
        if (st_en) begin
            for (int k = 0; k < 8; k++) begin
                st_a[k] = chain[k];
                st_b[k] = chain[8 + k];
            end
        end
        if (sh_en && clr_n) begin
            chain.push_front(din);
            void'(chain.pop_back());
        end
    end

    task automatic cmp(input string what, input logic [7:0] act, input logic [7:0] exp_v);
        n_cmp++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp_v);
        end
    endtask

    task automatic compare_all();
        cmp("par_q first",  qa_bus, oe_n ? 8'hFF : st_a);
        cmp("par_q second", qb_bus, oe_n ? 8'hFF : st_b);
        cmp("ser_out first",  {7'b0, so_a}, {7'b0, chain[7]});
        cmp("ser_out second", {7'b0, so_b}, {7'b0, chain[15]});
    endtask

    task automatic tick(input bit sh, input bit st, input bit d, input bit c, input bit o);
        @(negedge clk);
        compare_all();
        sh_en = sh;
        st_en = st;
        din   = d;
        oe_n  = o;
        clr_n = c;
        if (!c) begin
            for (int k = 0; k < 16; k++) chain[k] = 1'b0;
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        bit [7:0]  pat1 = 8'hB2;
        bit [7:0]  pat2 = 8'h5C;
        bit [15:0] lfsr = 16'hACE1;

        // R5: reset state, storage loaded from the cleared chain
        cur_req = "R5";
        tick(0, 1, 0, 0, 0);
        tick(0, 0, 0, 0, 0);
        tick(0, 0, 0, 1, 0);

        cur_req = "R1";
        for (int i = 0; i < 8; i++) tick(1, 0, pat1[i], 1, 0);
        cur_req = "R2";
        tick(1, 0, 1, 1, 0);
        tick(1, 0, 0, 1, 0);
        tick(0, 0, 0, 1, 0);

        cur_req = "R3";
        tick(0, 1, 0, 1, 0);
        tick(0, 0, 0, 1, 0);

        // R4: shifting without a transfer leaves the parallel word alone
        cur_req = "R4";
        for (int i = 0; i < 8; i++) tick(1, 0, pat2[i], 1, 0);
        tick(0, 0, 0, 1, 0);

        // R10: shift and transfer on the same edges
        cur_req = "R10";
        for (int i = 0; i < 6; i++) tick(1, 1, i[0], 1, 0);
        tick(0, 0, 0, 1, 0);

        // R7: outputs float while edges keep arriving
        cur_req = "R7";
        for (int i = 0; i < 4; i++) tick(1, 0, 1, 1, 1);
        tick(0, 1, 0, 1, 1);
        tick(0, 0, 0, 1, 1);
        cur_req = "R8";
        tick(0, 0, 0, 1, 0);
        tick(0, 0, 0, 1, 0);

        // R5 then R6: clear without clock, storage untouched
        cur_req = "R5";
        tick(0, 0, 0, 0, 0);
        cur_req = "R6";
        tick(0, 0, 0, 1, 0);
        tick(0, 0, 0, 1, 0);

        // R9: shift edges under a held clear
        cur_req = "R9";
        for (int i = 0; i < 4; i++) tick(1, 0, 1, 1, 0);
        for (int i = 0; i < 3; i++) tick(1, 0, 1, 0, 0);
        tick(0, 1, 0, 0, 0);
        tick(0, 0, 0, 1, 0);
        tick(0, 0, 0, 1, 0);

        // R11: two chained blocks act as one 16-stage register
        cur_req = "R11";
        for (int i = 0; i < 21; i++) begin
            tick(1, 0, lfsr[0], 1, 0);
            lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
        end
        tick(0, 1, 0, 1, 0);
        tick(0, 0, 0, 1, 0);
        tick(0, 0, 0, 1, 0);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog %s: actual hung expected finished", cur_req);
            summary();
            $finish;
        end
    end
endmodule